// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous request stream and an asynchronous static RAM with a 20-bit word address and a 4-bit shared data bus. A requester presents a read or write on a valid/ready handshake. The block then produces the active-low chip select, write enable and output enable strobes and the address. It also drives the write data together with the enable of the block's own bus drivers. Every phase of an access is a count of clock cycles set by a parameter. Each count is the nanosecond figure divided by the clock period and rounded up. At the default 100 MHz clock, every phase lasts one cycle.

A write is timed by the write-enable line. Chip select and write enable fall on the same clock edge while output enable stays high, so the RAM never drives the bus during a write. Address and data are set up one phase before the strobes fall and held for one phase after they rise. A read lowers chip select and output enable together. The data pins are sampled on the edge that ends the read phase, and the result is returned one cycle later on a valid strobe. Between accesses chip select stays high, which keeps the RAM in its low-power state. When a write follows a read, extra idle cycles are inserted before the block turns on its bus drivers.

Back-pressure: `req_ready` is high only while the controller is idle. A request transfers on a clock edge where both `req_valid` and `req_ready` are high. A requester may hold `req_valid` high while `req_ready` is low, and nothing is consumed. The response channel has no ready signal: `rsp_valid` lasts exactly one cycle and must be taken when it appears.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `ram_cs_n`, `ram_we_n` and `ram_oe_n` are 1, `ram_dq_oe` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: `req_ready` is 1 only when the controller is idle. While it is 0, `req_valid`, `req_write`, `req_addr` and `req_wdata` have no effect: `ram_addr` keeps the address of the access in progress, and no write to another address takes place.
- R3: A write drives `ram_addr` and `ram_dq_out` with `ram_dq_oe`=1 and all strobes high for T_ASU cycles. Then `ram_cs_n` and `ram_we_n` fall on the same edge and stay low for T_WP cycles. `ram_oe_n` stays 1 for the whole write.
- R4: A read holds `ram_cs_n`=0, `ram_oe_n`=0 and `ram_we_n`=1 for T_RD cycles. `ram_dq_in` is sampled on the edge that ends that phase and appears on `rsp_rdata`, with `rsp_valid`=1, in the next cycle.
- R5: `ram_addr` does not change while `ram_cs_n` is 0. After the write strobes rise, `ram_addr` and `ram_dq_out` stay unchanged, with `ram_dq_oe`=1, for T_WH more cycles.
- R6: A write accepted after a read spends T_TURN cycles with all strobes high and `ram_dq_oe`=0 before its setup phase.
- R7: `ram_dq_oe` is 0 in the cycle before any cycle in which `ram_oe_n` is 0.
- R8: `ram_dq_oe` and a low `ram_oe_n` never occur in the same cycle.
- R9: Whenever the controller is idle, `ram_cs_n` is 1.
- R10: Each read produces exactly one one-cycle `rsp_valid` pulse, and a write produces none.
- R11: The number of busy cycles from acceptance until `req_ready` returns is T_ASU+T_WP+T_WH for a write (plus T_TURN if the previous access was a read) and T_RD for a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | One-cycle strobe for read data |
| rsp_rdata | output | DW | Read data |
| ram_addr | output | AW | RAM address lines |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | DW | Data the controller drives onto the bus |
| ram_dq_oe | output | 1 | Enable of the controller's bus drivers |
| ram_dq_in | input | DW | Data received from the bus |

## Verification
The hardest situation to reach from the ports is a write that arrives directly after a read, where the turnaround gap has to separate the RAM's output drive from the controller's own. The vector table alternates reads and writes on purpose, so that both read-to-write and write-to-read boundaries come up several times. The bench's RAM model flags any cycle in which both sides drive the bus, and any cycle in which the controller drives right before output enable falls. A second awkward case is a request that is held valid while the controller is busy. A directed test holds `req_valid` high with a different address during a write, withdraws it before ready returns, and then reads that address back to confirm it was never written.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  // Access phases of the controller
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_TURN   = 3'd1,
    ST_WSETUP = 3'd2,
    ST_WPULSE = 3'd3,
    ST_WHOLD  = 3'd4,
    ST_RACC   = 3'd5
  } phase_e;

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_seq.sv
module sram_seq
  import sram_ctrl_pkg::*;
#(
  parameter int T_ASU  = 1,
  parameter int T_WP   = 1,
  parameter int T_WH   = 1,
  parameter int T_RD   = 1,
  parameter int T_TURN = 1,
  parameter int CW     = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  output logic          req_ready,
  output logic          accept,
  output logic          capture,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          ram_cs_n,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic          ram_dq_oe
);

  phase_e st, nxt;
  logic   last_rd;

  function automatic logic [CW-1:0] phase_len_m1(phase_e p);
    case (p)
      ST_TURN:   return CW'(T_TURN - 1);
      ST_WSETUP: return CW'(T_ASU - 1);
      ST_WPULSE: return CW'(T_WP - 1);
      ST_WHOLD:  return CW'(T_WH - 1);
      ST_RACC:   return CW'(T_RD - 1);
      default:   return '0;
    endcase
  endfunction

  always_comb begin
    nxt = st;
    case (st)
      ST_IDLE:
        if (req_valid) begin
          if (req_write) nxt = last_rd ? ST_TURN : ST_WSETUP;
          else           nxt = ST_RACC;
        end
      ST_TURN:   if (tmr_done) nxt = ST_WSETUP;
      ST_WSETUP: if (tmr_done) nxt = ST_WPULSE;
      ST_WPULSE: if (tmr_done) nxt = ST_WHOLD;
      ST_WHOLD:  if (tmr_done) nxt = ST_IDLE;
      ST_RACC:   if (tmr_done) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (st == ST_RACC) && tmr_done;
  assign tmr_load  = (nxt != st);
  assign tmr_val   = phase_len_m1(nxt);

  // State and pin flops: pins are registered from the next phase so they
  // change on the same edge as the state and never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      last_rd   <= 1'b0;
      ram_cs_n  <= 1'b1;
      ram_we_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
      ram_dq_oe <= 1'b0;
    end else begin
      st        <= nxt;
      if (capture)                                   last_rd <= 1'b1;
      else if (nxt == ST_WSETUP && st != ST_WSETUP)  last_rd <= 1'b0;
      ram_cs_n  <= !(nxt == ST_WPULSE || nxt == ST_RACC);
      ram_we_n  <= !(nxt == ST_WPULSE);
      ram_oe_n  <= !(nxt == ST_RACC);
      ram_dq_oe <= (nxt == ST_WSETUP) || (nxt == ST_WPULSE) || (nxt == ST_WHOLD);
    end
  end

  // R8: the controller never drives while the RAM outputs are enabled
  p_no_contention_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> ram_oe_n);

  // R3: output enable stays high throughout the write strobe
  p_we_oe_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> ram_oe_n);

  // R3: write enable and chip select fall together
  p_strobes_fall_together_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_we_n) |-> $fell(ram_cs_n));

  // R7: bus drivers released a full cycle before output enable falls
  p_release_before_oe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ram_oe_n) |-> !$past(ram_dq_oe));

  // R6: drivers turn on only after a cycle with output enable high
  p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> ($past(ram_oe_n) && ram_cs_n));

  // R5: data still driven when the write strobe rises
  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> ram_dq_oe);

  // R9: idle means deselected and not driving
  p_idle_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_cs_n && ram_we_n && !ram_dq_oe));

endmodule

// File: rtl/sram_dpath.sv
module sram_dpath #(
  parameter int AW = 20,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          capture,
  input  logic [DW-1:0] ram_dq_in,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_dq_out,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (accept) begin
        ram_addr   <= req_addr;
        ram_dq_out <= req_wdata;
      end
      rsp_valid <= capture;
      if (capture) rsp_rdata <= ram_dq_in;
    end
  end

  // R10: response strobe lasts exactly one cycle
  p_rsp_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int AW     = 20,
  parameter int DW     = 4,
  parameter int T_ASU  = 1,
  parameter int T_WP   = 1,
  parameter int T_WH   = 1,
  parameter int T_RD   = 1,
  parameter int T_TURN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs_n,
  output logic          ram_we_n,
  output logic          ram_oe_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  localparam int M_A  = (T_ASU > T_WP) ? T_ASU : T_WP;
  localparam int M_B  = (T_WH > T_RD) ? T_WH : T_RD;
  localparam int M_C  = (M_A > M_B) ? M_A : M_B;
  localparam int MAXD = (M_C > T_TURN) ? M_C : T_TURN;
  localparam int CW   = (MAXD > 1) ? $clog2(MAXD) : 1;

  logic          accept, capture, tmr_done, tmr_load;
  logic [CW-1:0] tmr_val;

  sram_seq #(
    .T_ASU(T_ASU), .T_WP(T_WP), .T_WH(T_WH), .T_RD(T_RD), .T_TURN(T_TURN), .CW(CW)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_ready(req_ready),
    .accept(accept), .capture(capture),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n), .ram_dq_oe(ram_dq_oe)
  );

  sram_phase_timer #(.CW(CW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_dpath #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n),
    .accept(accept), .req_addr(req_addr), .req_wdata(req_wdata),
    .capture(capture), .ram_dq_in(ram_dq_in),
    .ram_addr(ram_addr), .ram_dq_out(ram_dq_out),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  // R5: address frozen while the RAM is selected and into the next cycle
  p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |=> $stable(ram_addr));

  // R2: nothing reaches the address lines while busy
  p_busy_addr_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |=> $stable(ram_addr));

endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;

  localparam int AW = 20;
  localparam int DW = 4;
  localparam int T_ASU = 1, T_WP = 1, T_WH = 1, T_RD = 1, T_TURN = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [DW-1:0] rsp_rdata, ram_dq_out, ram_dq_in;
  logic [AW-1:0] ram_addr;

  int checks = 0, failures = 0, cycles = 0;

  always #2 clk = ~clk;

  sram_ctrl #(.AW(AW), .DW(DW), .T_ASU(T_ASU), .T_WP(T_WP), .T_WH(T_WH),
              .T_RD(T_RD), .T_TURN(T_TURN)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .ram_addr(ram_addr),
    .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural RAM (256 words, low address byte) ----------
  logic [DW-1:0] mem [256];
  logic ram_drv;
  assign ram_drv   = !ram_cs_n && !ram_oe_n && ram_we_n;
  assign ram_dq_in = ram_drv ? mem[ram_addr[7:0]] : '0;

  logic          p_wact = 1'b0, p_cs_n = 1'b1, p_dq_oe = 1'b0;
  logic [AW-1:0] p_addr = '0, w_addr = '0;
  logic [DW-1:0] w_data = '0;
  int            wcnt = 0;

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ram_cs_n && !ram_we_n) begin
        if (!p_wact) chk(p_cs_n == 1'b1, "R3 cs/we fall together", {31'd0, p_cs_n}, 32'd1);
        chk(ram_oe_n && ram_dq_oe, "R3 oe high and data driven in strobe",
            {30'd0, ram_oe_n, ram_dq_oe}, 32'd3);
        wcnt++;
        w_addr = ram_addr;
        w_data = ram_dq_out;
      end
      if (p_wact && !(!ram_cs_n && !ram_we_n)) begin
        chk(wcnt >= T_WP, "R3 write pulse width", wcnt, T_WP);
        chk(ram_dq_oe && ram_dq_out == w_data && ram_addr == w_addr,
            "R5 hold after strobe", {ram_dq_oe, ram_dq_out}, {1'b1, w_data});
        mem[w_addr[7:0]] = w_data;
        wcnt = 0;
      end
      if (!ram_cs_n && !p_cs_n)
        chk(ram_addr == p_addr, "R5 address stable while selected", ram_addr, p_addr);
      if (ram_drv) begin
        chk(!ram_dq_oe, "R8 bus contention", ram_dq_oe, 0);
        chk(!p_dq_oe, "R7 released before oe", p_dq_oe, 0);
      end
      p_wact  = !ram_cs_n && !ram_we_n;
      p_cs_n  = ram_cs_n;
      p_dq_oe = ram_dq_oe;
      p_addr  = ram_addr;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  // {write, addr[19:0], data[3:0]}
  localparam logic [24:0] VEC [0:11] = '{
    {1'b1, 20'h00000, 4'hA}, {1'b1, 20'hFFFFF, 4'h5}, {1'b0, 20'hFFFFF, 4'h0},
    {1'b1, 20'h00012, 4'h3}, {1'b0, 20'h00000, 4'h0}, {1'b0, 20'h00012, 4'h0},
    {1'b1, 20'h00012, 4'hC}, {1'b1, 20'h00034, 4'hF}, {1'b0, 20'h00012, 4'h0},
    {1'b0, 20'h00034, 4'h0}, {1'b1, 20'h00080, 4'h6}, {1'b0, 20'h00080, 4'h0}
  };

  logic [DW-1:0] shadow [256];
  bit prev_rd = 1'b0;

  // Present a request at a negedge and return right after the accepting edge
  task automatic send(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
  endtask

  task automatic run_op(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int n = 0;
    bit got = 0;
    logic [DW-1:0] rd = '0;
    int exp_busy;
    exp_busy = wr ? (T_ASU + T_WP + T_WH + (prev_rd ? T_TURN : 0)) : T_RD;
    send(wr, a, d);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      n++;
      if (rsp_valid) begin
        if (got) chk(0, "R10 second response", 2, 1);
        got = 1; rd = rsp_rdata;
      end
      if (req_ready) break;
    end
    chk(n - 1 == exp_busy, "R11 busy cycles", n - 1, exp_busy);
    chk(ram_cs_n, "R9 deselected when idle", ram_cs_n, 1);
    if (wr) begin
      chk(!got, "R10 no response on write", got, 0);
      shadow[a[7:0]] = d;
    end else begin
      chk(got, "R10 read response", got, 1);
      chk(rd == shadow[a[7:0]], "R4 read data", rd, shadow[a[7:0]]);
    end
    prev_rd = !wr;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) shadow[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    chk({ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid, req_ready} == 6'b111001,
        "R1 reset state", {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe, rsp_valid, req_ready}, 6'b111001);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && ram_cs_n, "R1 idle after reset", {req_ready, ram_cs_n}, 2'b11);

    // Vector walk
    for (int i = 0; i < 12; i++) run_op(VEC[i][24], VEC[i][23:4], VEC[i][3:0]);

    // R3/R5 cycle-by-cycle write after write (previous op was a read -> do a write first)
    run_op(1'b1, 20'h00040, 4'h9);
    send(1'b1, 20'h00041, 4'h2);
    @(negedge clk);
    chk({ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe} == 4'b1111 && ram_addr == 20'h00041 && ram_dq_out == 4'h2,
        "R3 setup phase", {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b1111);
    @(negedge clk);
    chk({ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe} == 4'b0011, "R3 strobe phase",
        {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b0011);
    @(negedge clk);
    chk({ram_cs_n, ram_we_n, ram_dq_oe} == 3'b111 && ram_dq_out == 4'h2 && ram_addr == 20'h00041,
        "R5 hold phase", {ram_cs_n, ram_we_n, ram_dq_oe, ram_dq_out}, {3'b111, 4'h2});
    @(negedge clk);
    chk(req_ready && !ram_dq_oe, "R11 idle after hold", {req_ready, ram_dq_oe}, 2'b10);
    shadow[8'h41] = 4'h2;
    prev_rd = 1'b0;

    // R4: read with cycle detail
    send(1'b0, 20'h00041, 4'h0);
    @(negedge clk);
    chk({ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe} == 4'b0100 && !rsp_valid, "R4 read phase",
        {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b0100);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 4'h2, "R4 response", {rsp_valid, rsp_rdata}, {1'b1, 4'h2});
    @(negedge clk);
    chk(!rsp_valid, "R10 single pulse", rsp_valid, 0);

    // R6: write after read has a turnaround cycle
    send(1'b1, 20'h00042, 4'h7);
    @(negedge clk);
    chk({ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe} == 4'b1110, "R6 turnaround gap",
        {ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe}, 4'b1110);
    @(negedge clk);
    chk(ram_dq_oe && ram_cs_n, "R6 drive after gap", {ram_dq_oe, ram_cs_n}, 2'b11);
    repeat (3) @(negedge clk);
    shadow[8'h42] = 4'h7;

    // R2: request held while busy, then withdrawn before ready
    send(1'b1, 20'h00043, 4'h1);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 20'h00050; req_wdata = 4'hE;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!req_ready && ram_addr == 20'h00043, "R2 busy ignores request", ram_addr, 20'h00043);
      if (k == 2) req_valid = 1'b0;
    end
    @(negedge clk);
    chk(req_ready && ram_addr == 20'h00043, "R2 withdrawn request not taken", ram_addr, 20'h00043);
    shadow[8'h43] = 4'h1;
    prev_rd = 1'b0;
    run_op(1'b0, 20'h00050, 4'h0);
    run_op(1'b0, 20'h00043, 4'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule